// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block divides a fast, clock-enabled input by a programmable integer N = B·P + A. It models a prescaler that can count either P or P+1 enabled input cycles, and sequences it with two down-counters. The swallow counter (A) holds the prescaler at P+1 for its first A periods. The main counter (B) sets how many prescaler periods make up one output cycle. When B reaches its last period, the block emits a one-cycle output pulse and reloads both counters together.

Software writes a new A, B and prescaler choice with a load strobe. Each write is checked. A legal write is held in a pending slot and takes effect at the next B timeout, so every output cycle is built from one configuration only. An illegal write (B of zero, or B smaller than A) raises an error flag and is discarded, and the running configuration stays in use. A later legal write clears the flag. The prescaler choice selects between a small pair (default 8/9) and a large pair (default 32/33).

Top module: `dm_swallow_div`

## Requirements
- R1: With the small prescaler (P = 8), consecutive output pulses are exactly B·P + A enabled input cycles apart. This holds for any legal A and B, including A = P−1 and the lowest contiguous setting A = 0, B = P−1 (N = 56).
- R2: `cfg_psel` = 1 selects P = 32 and `cfg_psel` = 0 selects P = 8. With the large prescaler the spacing is B·32 + A, with 992 (A = 0, B = 31) as the lowest contiguous N.
- R3: `mod_ctl` is 1 (prescaler at P+1) during the first A prescaler periods of every output cycle and 0 after that, so it is high for A·(P+1) cycles per output cycle. It is never high when A = 0.
- R4: `div_pulse` is high for exactly one clock per output cycle.
- R5: A legal load takes effect only at the next B timeout. The output cycle in progress when the load arrives keeps its old length and modulus.
- R6: A load with B = 0 or B < A sets `cfg_err` one clock later and leaves the divide ratio unchanged. A later legal load clears `cfg_err`.
- R7: Only clocks with `vco_en` = 1 advance the divider. With the enable high on every other clock, the pulse spacing is 2·N clocks.
- R8: While reset is held, `div_pulse`, `mod_ctl` and `cfg_err` are 0. After reset the divider runs with A = 0, B = 4 and the small prescaler (N = 32).
- R9: When B equals A, every prescaler period uses P+1, so N = A·(P+1) and `mod_ctl` stays high through the whole output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input (oscillator-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vco_en | input | 1 | Clock enable; one enabled cycle is one input cycle |
| cfg_a | input | A_W (6) | Swallow count A to load |
| cfg_b | input | B_W (13) | Main count B to load |
| cfg_psel | input | 1 | Prescaler pair: 0 = small (8/9), 1 = large (32/33) |
| cfg_load | input | 1 | One-clock strobe that samples cfg_a, cfg_b, cfg_psel |
| div_pulse | output | 1 | One-clock pulse, once per N enabled input cycles |
| mod_ctl | output | 1 | 1 while the prescaler divides by P+1 |
| cfg_err | output | 1 | Last load was illegal and was discarded |

## Verification
The divide ratio is measured as the distance between pulses for several kinds of setting. A mixed setting with both counters nonzero shows whether the two moduli are summed correctly. A = 0 and A = B are the cases where only one modulus is used. The A = P−1 and minimum-contiguous settings test the edges of the integer range. Each setting is also run with the large prescaler. The number of cycles with `mod_ctl` high tells a wrong swallow count apart from a wrong main count. The first interval after every load shows whether the change waited for the cycle boundary. Illegal loads are followed by interval measurements, which show that the old ratio is still in use, and a gated-enable run shows that disabled clocks are not counted.

// File: rtl/dm_div_pkg.sv
package dm_div_pkg;
  typedef enum logic {
    PS_SMALL = 1'b0,
    PS_LARGE = 1'b1
  } psel_e;
endpackage

// File: rtl/dm_rst_sync.sv
module dm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/dm_cfg_regs.sv
module dm_cfg_regs
  import dm_div_pkg::*;
#(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int DEF_A = 0,
  parameter int DEF_B = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           ps_in,
  input  logic           reload,
  output logic [A_W-1:0] ld_a,
  output logic [B_W-1:0] ld_b,
  output psel_e          act_ps,
  output logic           err
);
  localparam int PADW = B_W - A_W;

  logic [A_W-1:0] act_a_q, act_a_d, pend_a_q, pend_a_d;
  logic [B_W-1:0] act_b_q, act_b_d, pend_b_q, pend_b_d;
  psel_e          act_ps_q, act_ps_d, pend_ps_q, pend_ps_d;
  logic           pend_v_q, pend_v_d;
  logic           err_q, err_d;
  logic           legal;

  assign legal = (b_in != '0) && (b_in >= {{PADW{1'b0}}, a_in});

  always_comb begin
    act_a_d   = act_a_q;
    act_b_d   = act_b_q;
    act_ps_d  = act_ps_q;
    pend_a_d  = pend_a_q;
    pend_b_d  = pend_b_q;
    pend_ps_d = pend_ps_q;
    pend_v_d  = pend_v_q;
    err_d     = err_q;
    if (reload && pend_v_q) begin
      act_a_d  = pend_a_q;
      act_b_d  = pend_b_q;
      act_ps_d = pend_ps_q;
      pend_v_d = 1'b0;
    end
    if (load) begin
      if (legal) begin
        pend_a_d  = a_in;
        pend_b_d  = b_in;
        pend_ps_d = psel_e'(ps_in);
        pend_v_d  = 1'b1;
        err_d     = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a_q   <= A_W'(DEF_A);
      act_b_q   <= B_W'(DEF_B);
      act_ps_q  <= PS_SMALL;
      pend_a_q  <= '0;
      pend_b_q  <= '0;
      pend_ps_q <= PS_SMALL;
      pend_v_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      act_a_q   <= act_a_d;
      act_b_q   <= act_b_d;
      act_ps_q  <= act_ps_d;
      pend_a_q  <= pend_a_d;
      pend_b_q  <= pend_b_d;
      pend_ps_q <= pend_ps_d;
      pend_v_q  <= pend_v_d;
      err_q     <= err_d;
    end
  end

  assign ld_a   = pend_v_q ? pend_a_q : act_a_q;
  assign ld_b   = pend_v_q ? pend_b_q : act_b_q;
  assign act_ps = act_ps_q;
  assign err    = err_q;

  // R5: the running configuration moves only at a B timeout
  a_r5_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ($stable(act_a_q) && $stable(act_b_q) && $stable(act_ps_q)));

  // R6: the running configuration is always a legal one
  a_r6_act_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b_q != '0) && (act_b_q >= {{PADW{1'b0}}, act_a_q}));
endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler
  import dm_div_pkg::*;
#(
  parameter int P_LO = 8,
  parameter int P_HI = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  psel_e ps,
  input  logic  mod_hi,
  output logic  pre_tc
);
  localparam int PC_W = $clog2(P_HI + 2);

  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic [PC_W-1:0] mod_len;

  assign mod_len = ((ps == PS_LARGE) ? PC_W'(P_HI) : PC_W'(P_LO)) + PC_W'(mod_hi);
  assign pre_tc  = en && (pcnt_q == mod_len - PC_W'(1));

  always_comb begin
    pcnt_d = pcnt_q;
    if (en) begin
      pcnt_d = pre_tc ? '0 : pcnt_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R2/R3: the phase count stays inside the modulus now in force
  a_r2_pcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < mod_len);
endmodule

// File: rtl/dm_swallow_ctr.sv
module dm_swallow_ctr #(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int DEF_A = 0,
  parameter int DEF_B = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tc,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           mod_hi,
  output logic           timeout,
  output logic           pulse
);
  localparam int PADW = B_W - A_W;

  logic [A_W-1:0] a_q, a_d;
  logic [B_W-1:0] b_q, b_d;
  logic           pulse_q;

  assign timeout = pre_tc && (b_q == B_W'(1));
  assign mod_hi  = (a_q != '0);

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (timeout) begin
      a_d = ld_a;
      b_d = ld_b;
    end else if (pre_tc) begin
      b_d = b_q - B_W'(1);
      if (a_q != '0) a_d = a_q - A_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= A_W'(DEF_A);
      b_q     <= B_W'(DEF_B);
      pulse_q <= 1'b0;
    end else begin
      a_q     <= a_d;
      b_q     <= b_d;
      pulse_q <= timeout;
    end
  end

  assign pulse = pulse_q;

  // R1: the main counter never sits at zero
  a_r1_b_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    b_q != '0);

  // R9: the swallow count never outruns the main count
  a_r9_b_covers_a: assert property (@(posedge clk) disable iff (!rst_n)
    b_q >= {{PADW{1'b0}}, a_q});

  // R4: the output pulse lasts one clock
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/dm_swallow_div.sv
module dm_swallow_div
  import dm_div_pkg::*;
#(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int P_LO  = 8,
  parameter int P_HI  = 32,
  parameter int DEF_A = 0,
  parameter int DEF_B = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_en,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  input  logic           cfg_psel,
  input  logic           cfg_load,
  output logic           div_pulse,
  output logic           mod_ctl,
  output logic           cfg_err
);
  logic           rst_i_n;
  logic [A_W-1:0] ld_a;
  logic [B_W-1:0] ld_b;
  psel_e          act_ps;
  logic           pre_tc;
  logic           mod_hi;
  logic           timeout;

  dm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dm_cfg_regs #(
    .A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load   (cfg_load),
    .a_in   (cfg_a),
    .b_in   (cfg_b),
    .ps_in  (cfg_psel),
    .reload (timeout),
    .ld_a   (ld_a),
    .ld_b   (ld_b),
    .act_ps (act_ps),
    .err    (cfg_err)
  );

  dm_prescaler #(
    .P_LO(P_LO), .P_HI(P_HI)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .en     (vco_en),
    .ps     (act_ps),
    .mod_hi (mod_hi),
    .pre_tc (pre_tc)
  );

  dm_swallow_ctr #(
    .A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .pre_tc  (pre_tc),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .mod_hi  (mod_hi),
    .timeout (timeout),
    .pulse   (div_pulse)
  );

  assign mod_ctl = mod_hi;
endmodule

// File: tb/sim_dm_swallow_div.sv
module sim_dm_swallow_div;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vco_en;
  logic [5:0]  cfg_a;
  logic [12:0] cfg_b;
  logic        cfg_psel;
  logic        cfg_load;
  logic        div_pulse;
  logic        mod_ctl;
  logic        cfg_err;
  logic        gap_mode = 1'b0;
  int          n_tests = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_swallow_div u0 (
    .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .cfg_psel(cfg_psel), .cfg_load(cfg_load), .div_pulse(div_pulse),
    .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  initial begin
    vco_en = 1'b1;
    forever begin
      @(negedge clk);
      vco_en = gap_mode ? ~vco_en : 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  // Starts on the clock sample where div_pulse is high.
  task automatic measure(output int len, output int mc, output int wide);
    len = 0; mc = 0; wide = 0;
    do begin
      if (mod_ctl) mc++;
      @(negedge clk);
      cfg_load = 1'b0;
      len++;
      if (len == 1) wide = int'(div_pulse);
    end while (!div_pulse);
  endtask

  task automatic drive_cfg(input int a, input int b, input bit ps);
    cfg_a = 6'(a); cfg_b = 13'(b); cfg_psel = ps; cfg_load = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_load = 1'b0; cfg_a = '0; cfg_b = '0; cfg_psel = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 pulse in reset", int'(div_pulse), 0);
    chk("R8 mod_ctl in reset", int'(mod_ctl), 0);
    chk("R8 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_default();
    int len, mc, w;
    wait_pulse();
    measure(len, mc, w);
    chk("R8 default period", len, 32);
    chk("R3 default mod_ctl count", mc, 0);
  endtask

  task automatic t_cfg(input string req, input int a, input int b, input bit ps,
                       input int old_n, input int new_n, input int new_mc);
    int len, mc, w;
    wait_pulse();
    drive_cfg(a, b, ps);
    measure(len, mc, w);
    if (old_n >= 0) chk("R5 old length kept", len, old_n);
    measure(len, mc, w);
    chk(req, len, new_n);
    chk("R3 mod_ctl count", mc, new_mc);
    chk("R4 pulse width", w, 0);
  endtask

  task automatic t_illegal();
    int len, mc, w;
    wait_pulse();
    drive_cfg(5, 3, 1'b0);
    @(negedge clk); cfg_load = 1'b0;
    chk("R6 err on B<A", int'(cfg_err), 1);
    wait_pulse();
    measure(len, mc, w);
    chk("R6 ratio kept after B<A", len, 63);
    drive_cfg(0, 0, 1'b1);
    @(negedge clk); cfg_load = 1'b0;
    chk("R6 err on B=0", int'(cfg_err), 1);
    wait_pulse();
    measure(len, mc, w);
    chk("R6 ratio kept after B=0", len, 63);
    drive_cfg(1, 2, 1'b0);
    @(negedge clk); cfg_load = 1'b0;
    chk("R6 err cleared by legal load", int'(cfg_err), 0);
    wait_pulse();
    measure(len, mc, w);
    chk("R6 legal load applied", len, 17);
  endtask

  task automatic t_gap();
    int len, mc, w;
    gap_mode = 1'b1;
    wait_pulse();
    wait_pulse();
    measure(len, mc, w);
    chk("R7 gated enable doubles spacing", len, 34);
    gap_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_default();
    t_cfg("R1 mixed A=3 B=10", 3, 10, 1'b0, 32, 83, 27);
    t_cfg("R2 large prescaler A=5 B=7", 5, 7, 1'b1, 83, 229, 165);
    t_cfg("R9 B equals A", 5, 5, 1'b0, 229, 45, 45);
    t_cfg("R1 lowest contiguous N", 0, 7, 1'b0, 45, 56, 0);
    t_cfg("R1 A at P-1", 7, 7, 1'b0, 56, 63, 63);
    t_illegal();
    t_gap();
    t_cfg("R2 lowest contiguous N large", 0, 31, 1'b1, -1, 992, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule